// File: doc/BRIEF.md
# Ring Detect Sample Encoder

This block watches a stream of signed line-voltage samples, one per sample strobe, and classifies each one against a programmable positive threshold and a programmable negative threshold. From that classification it registers two ring flags and builds a synthetic 16-bit data word. A host link can send that word in place of ordinary receive audio while the line is idle and ringing.

The word uses one of two codings, chosen by a full-wave enable. The two-level coding is a near square wave between the most negative and most positive codes. The three-level coding adds a small positive idle code for samples between the thresholds. In both codings the word's sign bit toggles once per ring cycle, so software can measure ring frequency from that bit alone.

A ring-indicator status bit follows ring activity. A timeout counter drops the bit after a long run of quiet samples. Going off-hook clears the bit at once.

Top module: `ring_sample_encoder`

## Requirements
- R1: On a strobe, `ring_pos` is registered as 1 exactly when `sample_in` is strictly greater than `thr_pos` (signed); a sample equal to `thr_pos` gives 0.
- R2: On a strobe, `ring_neg` is registered as 1 exactly when `sample_in` is strictly less than `thr_neg` (signed); a sample equal to `thr_neg` gives 0.
- R3: With `fullwave_en` = 0, a strobe registers `ring_word` = 16'h7FFF for a sample above `thr_pos`, and 16'h8000 for every other sample.
- R4: With `fullwave_en` = 1, a strobe registers `ring_word` = 16'h7FFF above `thr_pos`, 16'h8000 below `thr_neg`, and 16'h04CC (+1228) in between.
- R5: Every clock, `ring_sel` is registered as `link_active` AND NOT `off_hook` AND NOT `line_mon`.
- R6: With `fullwave_en` = 0, a strobe where either flag would be set drives `ring_ind` to 1 on the next cycle.
- R7: With `fullwave_en` = 1, a strobe where either flag would be set drives `ring_ind` to 0. A following quiet strobe drives it back to 1 while the timeout is still running. The indicator therefore pulses low once per excursion, which is twice per ring cycle.
- R8: A strobe with a flag set reloads a 65536-sample timeout. Each quiet strobe counts it down. `ring_ind` stays 1 through the first 65535 quiet strobes and drops to 0 on the 65536th. Cycles without a strobe do not count.
- R9: `off_hook` high at a clock edge forces `ring_ind` to 0 on the next cycle and cancels the timeout, even if that edge also carries a ringing strobe.
- R10: After reset, `ring_pos`, `ring_neg`, `ring_ind` and `ring_sel` are 0 and `ring_word` is 16'h8000.
- R11: On cycles with `sample_vld` low, `ring_pos`, `ring_neg`, `ring_word` and `ring_ind` keep their values whatever `sample_in` does, unless R9 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | 1 | Sample strobe, one cycle per sample slot |
| sample_in | input | 16 | Signed line-voltage sample |
| thr_pos | input | 16 | Signed positive ring threshold |
| thr_neg | input | 16 | Signed negative ring threshold |
| fullwave_en | input | 1 | 1 selects the three-level coding and the per-excursion indicator |
| link_active | input | 1 | Isolation link is up |
| off_hook | input | 1 | Line is off-hook |
| line_mon | input | 1 | On-hook line monitor mode is active |
| ring_pos | output | 1 | Sample above the positive threshold |
| ring_neg | output | 1 | Sample below the negative threshold |
| ring_word | output | 16 | Synthetic ring data word |
| ring_sel | output | 1 | Ring word replaces normal receive data |
| ring_ind | output | 1 | Ring-indicator status bit |

## Verification
The bench sets samples exactly on each threshold. A design that compares with >= or <= would raise a flag there, and would also emit the ringing code one step early. It runs the timeout through 65535 quiet strobes and then one more. A counter that is one short or one long would drop the indicator a sample early or hold it a sample too long. It also lands an off-hook on the same edge as a ringing strobe, which a design that gives the reload priority would get wrong. Long random runs switch the coding mode, interleave idle cycles, and toggle the selection inputs. A mixed-up idle code, a missing idle hold or a wrong selection term shows up there as a word or flag mismatch.

// File: rtl/rdse_pkg.sv
package rdse_pkg;
    // classification of one sample against the two thresholds
    typedef enum logic [1:0] {
        LVL_MID = 2'd0,
        LVL_POS = 2'd1,
        LVL_NEG = 2'd2
    } rdse_level_e;
endpackage

// File: rtl/rdse_thresh.sv
module rdse_thresh #(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic signed [SAMPLE_W-1:0] thr_pos,
    input  logic signed [SAMPLE_W-1:0] thr_neg,
    output logic                       above,
    output logic                       below,
    output rdse_pkg::rdse_level_e      level
);
    import rdse_pkg::*;

    always_comb begin
        above = (sample_in > thr_pos);
        below = (sample_in < thr_neg);
        // positive wins if the thresholds are programmed crossed
        if (above)      level = LVL_POS;
        else if (below) level = LVL_NEG;
        else            level = LVL_MID;
    end
endmodule

// File: rtl/rdse_encode.sv
module rdse_encode #(
    parameter int SAMPLE_W     = 16,
    parameter int FW_IDLE_CODE = 1228
) (
    input  rdse_pkg::rdse_level_e level,
    input  logic                  fullwave_en,
    output logic [SAMPLE_W-1:0]   word
);
    import rdse_pkg::*;

    localparam logic [SAMPLE_W-1:0] CODE_MAX  = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] CODE_MIN  = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] CODE_IDLE = SAMPLE_W'(FW_IDLE_CODE);

    always_comb begin
        unique case (level)
            LVL_POS: word = CODE_MAX;
            LVL_NEG: word = CODE_MIN;
            default: word = fullwave_en ? CODE_IDLE : CODE_MIN;
        endcase
    end
endmodule

// File: rtl/ring_sample_encoder.sv
module ring_sample_encoder #(
    parameter int SAMPLE_W        = 16,
    parameter int TIMEOUT_SAMPLES = 65536,
    parameter int FW_IDLE_CODE    = 1228
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_vld,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic signed [SAMPLE_W-1:0] thr_pos,
    input  logic signed [SAMPLE_W-1:0] thr_neg,
    input  logic                       fullwave_en,
    input  logic                       link_active,
    input  logic                       off_hook,
    input  logic                       line_mon,
    output logic                       ring_pos,
    output logic                       ring_neg,
    output logic [SAMPLE_W-1:0]        ring_word,
    output logic                       ring_sel,
    output logic                       ring_ind
);
    import rdse_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT_SAMPLES + 1);
    localparam logic [CNT_W-1:0]    CNT_LOAD  = CNT_W'(TIMEOUT_SAMPLES);
    localparam logic [CNT_W-1:0]    CNT_ONE   = CNT_W'(1);
    localparam logic [SAMPLE_W-1:0] WORD_RST  = {1'b1, {(SAMPLE_W-1){1'b0}}};

    typedef struct packed {
        logic                pos;
        logic                neg;
        logic [SAMPLE_W-1:0] word;
        logic                sel;
        logic                ind;
        logic [CNT_W-1:0]    cnt;
    } rdse_state_t;

    rdse_state_t st_d, st_q;

    logic                above, below;
    rdse_level_e         level;
    logic [SAMPLE_W-1:0] enc_word;

    rdse_thresh #(.SAMPLE_W(SAMPLE_W)) u_thresh (
        .sample_in (sample_in),
        .thr_pos   (thr_pos),
        .thr_neg   (thr_neg),
        .above     (above),
        .below     (below),
        .level     (level)
    );

    rdse_encode #(.SAMPLE_W(SAMPLE_W), .FW_IDLE_CODE(FW_IDLE_CODE)) u_encode (
        .level       (level),
        .fullwave_en (fullwave_en),
        .word        (enc_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = link_active & ~off_hook & ~line_mon;
        if (sample_vld) begin
            st_d.pos  = above;
            st_d.neg  = below;
            st_d.word = enc_word;
            if (above | below) begin
                st_d.cnt = CNT_LOAD;
                st_d.ind = ~fullwave_en;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_ONE;
                st_d.ind = (st_q.cnt != CNT_ONE);
            end
        end
        if (off_hook) begin
            st_d.cnt = '0;
            st_d.ind = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.word <= WORD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ring_pos  = st_q.pos;
    assign ring_neg  = st_q.neg;
    assign ring_word = st_q.word;
    assign ring_sel  = st_q.sel;
    assign ring_ind  = st_q.ind;
endmodule

// File: rtl/rdse_checker.sv
module rdse_checker #(
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sample_vld,
    input logic signed [SAMPLE_W-1:0] sample_in,
    input logic signed [SAMPLE_W-1:0] thr_pos,
    input logic signed [SAMPLE_W-1:0] thr_neg,
    input logic                       fullwave_en,
    input logic                       link_active,
    input logic                       off_hook,
    input logic                       line_mon,
    input logic                       ring_pos,
    input logic                       ring_neg,
    input logic [SAMPLE_W-1:0]        ring_word,
    input logic                       ring_sel,
    input logic                       ring_ind
);
    localparam logic [SAMPLE_W-1:0] CODE_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] CODE_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // R1
    pos_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && sample_in == thr_pos) |=> !ring_pos);

    // R1
    pos_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && sample_in > thr_pos) |=> ring_pos);

    // R2
    neg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && sample_in < thr_neg) |=> ring_neg);

    // R3
    pos_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_pos |-> (ring_word == CODE_MAX));

    // R3
    halfwave_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !fullwave_en && !(sample_in > thr_pos)) |=> (ring_word == CODE_MIN));

    // R5
    sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ring_sel == $past(link_active && !off_hook && !line_mon)));

    // R9
    offhook_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_hook |=> !ring_ind);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(ring_word) && $stable(ring_pos) && $stable(ring_neg)));
endmodule

bind ring_sample_encoder rdse_checker #(.SAMPLE_W(SAMPLE_W)) u_rdse_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .sample_in   (sample_in),
    .thr_pos     (thr_pos),
    .thr_neg     (thr_neg),
    .fullwave_en (fullwave_en),
    .link_active (link_active),
    .off_hook    (off_hook),
    .line_mon    (line_mon),
    .ring_pos    (ring_pos),
    .ring_neg    (ring_neg),
    .ring_word   (ring_word),
    .ring_sel    (ring_sel),
    .ring_ind    (ring_ind)
);

// File: tb/ring_sample_encoder_test.sv
module ring_sample_encoder_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_vld = 1'b0;
    logic signed [15:0] sample_in = '0;
    logic signed [15:0] thr_pos = 16'sd1000;
    logic signed [15:0] thr_neg = -16'sd1000;
    logic               fullwave_en = 1'b0;
    logic               link_active = 1'b0;
    logic               off_hook = 1'b0;
    logic               line_mon = 1'b0;
    logic               ring_pos, ring_neg, ring_sel, ring_ind;
    logic [15:0]        ring_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic        m_pos = 1'b0, m_neg = 1'b0, m_sel = 1'b0, m_ind = 1'b0;
    logic [15:0] m_word = 16'h8000;
    int          m_cnt = 0;

    always #4 clk = ~clk;

    ring_sample_encoder uut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_in(sample_in),
        .thr_pos(thr_pos), .thr_neg(thr_neg), .fullwave_en(fullwave_en),
        .link_active(link_active), .off_hook(off_hook), .line_mon(line_mon),
        .ring_pos(ring_pos), .ring_neg(ring_neg), .ring_word(ring_word),
        .ring_sel(ring_sel), .ring_ind(ring_ind)
    );

    function automatic logic [15:0] exp_word(logic fw, logic p, logic n);
        if (p)       return 16'h7FFF;
        else if (!fw) return 16'h8000;
        else if (n)  return 16'h8000;
        else         return 16'd1228;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        m_sel = link_active && !off_hook && !line_mon;
        if (sample_vld) begin
            m_pos  = sample_in > thr_pos;
            m_neg  = sample_in < thr_neg;
            m_word = exp_word(fullwave_en, m_pos, m_neg);
            if (m_pos || m_neg) begin
                m_cnt = 65536;
                m_ind = !fullwave_en;
            end else if (m_cnt != 0) begin
                m_cnt--;
                m_ind = (m_cnt != 0);
            end
        end
        if (off_hook) begin
            m_cnt = 0;
            m_ind = 1'b0;
        end
    endtask

    task automatic compare_all();
        chk("R1 ring_pos", 16'(ring_pos), 16'(m_pos));
        chk("R2 ring_neg", 16'(ring_neg), 16'(m_neg));
        chk(fullwave_en ? "R4 ring_word" : "R3 ring_word", ring_word, m_word);
        chk("R5 ring_sel", 16'(ring_sel), 16'(m_sel));
        chk("R6 R7 R8 R9 ring_ind", 16'(ring_ind), 16'(m_ind));
    endtask

    // apply inputs, clock once, update the model, compare
    task automatic step(logic vld, logic signed [15:0] s);
        sample_vld = vld;
        sample_in  = s;
        @(posedge clk);
        #1;
        model_edge();
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 reset ring_pos", 16'(ring_pos), 16'd0);
        chk("R10 reset ring_neg", 16'(ring_neg), 16'd0);
        chk("R10 reset ring_word", ring_word, 16'h8000);
        chk("R10 reset ring_sel", 16'(ring_sel), 16'd0);
        chk("R10 reset ring_ind", 16'(ring_ind), 16'd0);
        rst_n = 1'b1;
        link_active = 1'b1;

        // R1 R2 strict comparison at the thresholds, both modes
        for (int fw = 0; fw < 2; fw++) begin
            fullwave_en = fw[0];
            step(1'b1, 16'sd1000);
            chk("R1 equal to thr_pos", 16'(ring_pos), 16'd0);
            step(1'b1, 16'sd1001);
            chk("R1 one above thr_pos", 16'(ring_pos), 16'd1);
            step(1'b1, -16'sd1000);
            chk("R2 equal to thr_neg", 16'(ring_neg), 16'd0);
            chk("R4 R3 idle code", ring_word, fw ? 16'd1228 : 16'h8000);
            step(1'b1, -16'sd1001);
            chk("R2 one below thr_neg", 16'(ring_neg), 16'd1);
            chk("R3 R4 negative code", ring_word, 16'h8000);
        end

        // R7 indicator pulses low on each excursion in full-wave mode
        fullwave_en = 1'b1;
        step(1'b1, 16'sd5000);
        chk("R7 low on positive excursion", 16'(ring_ind), 16'd0);
        step(1'b1, 16'sd0);
        chk("R7 high between excursions", 16'(ring_ind), 16'd1);
        step(1'b1, -16'sd5000);
        chk("R7 low on negative excursion", 16'(ring_ind), 16'd0);

        // R6 half-wave indicator high on activity
        fullwave_en = 1'b0;
        step(1'b1, -16'sd5000);
        chk("R6 high on excursion", 16'(ring_ind), 16'd1);

        // R11 idle cycles hold outputs
        step(1'b0, 16'sd20000);
        chk("R11 word held", ring_word, 16'h8000);
        chk("R11 pos held", 16'(ring_pos), 16'd0);

        // R8 timeout: 65535 quiet strobes keep it, the next drops it
        for (int i = 0; i < 65535; i++) step(1'b1, 16'sd0);
        chk("R8 still set after 65535 quiet", 16'(ring_ind), 16'd1);
        step(1'b0, 16'sd0);
        chk("R8 idle cycle does not count", 16'(ring_ind), 16'd1);
        step(1'b1, 16'sd0);
        chk("R8 cleared on 65536th quiet", 16'(ring_ind), 16'd0);

        // R9 off-hook wins over a ringing strobe on the same edge
        step(1'b1, 16'sd9000);
        chk("R9 set before off-hook", 16'(ring_ind), 16'd1);
        off_hook = 1'b1;
        step(1'b1, 16'sd9000);
        chk("R9 off-hook clears", 16'(ring_ind), 16'd0);
        chk("R5 off-hook deselects", 16'(ring_sel), 16'd0);
        off_hook = 1'b0;
        step(1'b1, 16'sd0);
        chk("R9 timeout cancelled", 16'(ring_ind), 16'd0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic signed [15:0] s;
            if (i % 250 == 0) begin
                fullwave_en = $urandom_range(0, 1);
                thr_pos = 16'($urandom_range(0, 8000));
                thr_neg = -16'($urandom_range(0, 8000));
            end
            link_active = ($urandom_range(0, 9) != 0);
            line_mon    = ($urandom_range(0, 9) == 0);
            off_hook    = ($urandom_range(0, 49) == 0);
            case ($urandom_range(0, 3))
                0: s = thr_pos + 16'($urandom_range(0, 2)) - 16'sd1;
                1: s = thr_neg + 16'($urandom_range(0, 2)) - 16'sd1;
                default: s = 16'($urandom);
            endcase
            step($urandom_range(0, 3) != 0, s);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule